// File: doc/BRIEF.md
# Direct-Mapped Write-Back Byte Cache

This block sits between a processor-side byte port and a memory port that moves whole 16-byte blocks. It holds 256 lines. Each line has a 12-bit tag, a valid flag and a dirty flag. A processor read or write whose line is present completes in the cycle it is presented. Any other access starts a miss sequence. The sequence first saves a modified victim line to memory, then loads the requested block. After that the original access completes against the freshly loaded line.

Both ports use a valid/ready handshake.

- **Processor port:** the requester raises `cpu_valid` together with the address, the write flag and the write byte. It must hold all of them unchanged until it sees `cpu_ready` high at a clock edge. That edge is the one at which the access completes. For a read, `cpu_rdata` is meaningful during that cycle. For a write, the byte is stored at that edge.
- **Memory port:** the block raises `mem_valid` with the block address, the direction and (for a save) the line contents. It keeps all of them steady until the memory raises `mem_ready`. A transfer happens at each edge where both are high. The memory may stall for any number of cycles.

Top module: `dmwb_cache`

## Requirements
- R1: A processor address splits into tag = bits 23:12, line index = bits 11:4 and byte offset = bits 3:0. The memory block address is bits 23:4, so 0xAB7129 loads block 0xAB712 into line 0x12.
- R2: After reset every line is invalid. The first access to any line therefore misses.
- R3: An access to a valid line whose stored tag equals the address tag is a hit. `cpu_ready` is high in the same cycle as `cpu_valid`. A read returns the line byte at bits 8*offset+7 : 8*offset.
- R4: A write hit replaces only the addressed byte of the line and marks the line dirty.
- R5: A miss on an invalid line performs exactly one memory read of the requested block and no memory write.
- R6: A miss on a valid line with a different tag and a clear dirty flag discards the old contents. It performs one read of the requested block and no memory write.
- R7: A miss on a valid line with a different tag and a set dirty flag first writes the whole line to block {stored tag, line index}. Only then does it read the requested block.
- R8: A completed block load leaves the line valid and clean. The following access to the same block hits and returns the loaded bytes.
- R9: A write miss loads the block, then stores the byte into it. The line ends dirty with the new byte merged into the loaded data.
- R10: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged. In `mem_wdata` and `mem_rdata`, byte i of a block occupies bits 8i+7 : 8i.
- R11: `cpu_ready` stays low while a memory transfer is outstanding. The block returns `cpu_ready` in the cycle after the load completes.
- R12: A hit causes no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor access request |
| cpu_ready | output | 1 | Access completes at this edge |
| cpu_we | input | 1 | 1 = write byte, 0 = read byte |
| cpu_addr | input | 24 | Byte address |
| cpu_wdata | input | 8 | Byte to write |
| cpu_rdata | output | 8 | Byte read, meaningful while cpu_ready is high on a read |
| mem_valid | output | 1 | Memory block transfer request |
| mem_ready | input | 1 | Memory accepts or delivers the block |
| mem_we | output | 1 | 1 = save line to memory, 0 = load block |
| mem_addr | output | 20 | Block address |
| mem_wdata | output | 128 | Line contents being saved |
| mem_rdata | input | 128 | Block contents being loaded |

## Verification
Two interactions fall in the same or adjacent cycles:
- A write hit updates a byte and sets the dirty flag at the same edge.
- A conflicting miss to the same index can follow on the very next access, so its victim save must already carry that byte.

The bench provokes both by writing into a line and then touching another tag on that index. It compares the saved block against a byte-level model of the line. It also lets the memory answer in the first cycle of a request. That makes the end of a save and the start of a load adjacent, and the bench judges them by the exact order and addresses of the logged transfers.

// File: rtl/dmwb_cache_pkg.sv
`timescale 1ns/1ps
package dmwb_cache_pkg;
  localparam int unsigned ADDR_BITS = 24;
  localparam int unsigned IDX_BITS  = 8;
  localparam int unsigned OFF_BITS  = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SAVE  = 2'd1,
    ST_LOAD  = 2'd2
  } miss_state_e;
endpackage

// File: rtl/dmwb_addr_split.sv
`timescale 1ns/1ps
module dmwb_addr_split #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned OFF_W  = 4,
  localparam int unsigned TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [TAG_W-1:0]  tag,
  output logic [IDX_W-1:0]  idx,
  output logic [OFF_W-1:0]  off
);
  // Field order matters: the block address is {tag, idx}.
  always_comb begin
    tag = addr[ADDR_W-1 -: TAG_W];
    idx = addr[OFF_W +: IDX_W];
    off = addr[OFF_W-1:0];
  end
endmodule

// File: rtl/dmwb_tag_store.sv
`timescale 1ns/1ps
module dmwb_tag_store #(
  parameter int unsigned TAG_W = 12,
  parameter int unsigned IDX_W = 8,
  localparam int unsigned LINES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] look_idx,
  output logic [TAG_W-1:0] look_tag,
  output logic             look_valid,
  output logic             look_dirty,
  input  logic             load_en,
  input  logic [IDX_W-1:0] load_idx,
  input  logic [TAG_W-1:0] load_tag,
  input  logic             mark_en,
  input  logic [IDX_W-1:0] mark_idx
);
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (load_en) begin
        valid_q[load_idx] <= 1'b1;
        dirty_q[load_idx] <= 1'b0;
      end
      if (mark_en) begin
        dirty_q[mark_idx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) tag_q[load_idx] <= load_tag;
  end

  always_comb begin
    look_tag   = tag_q[look_idx];
    look_valid = valid_q[look_idx];
    look_dirty = dirty_q[look_idx];
  end

  p_load_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> valid_q[$past(load_idx)] && !dirty_q[$past(load_idx)])
    else $error("R8: loaded line not valid and clean");

  p_mark_dirty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mark_en |=> dirty_q[$past(mark_idx)])
    else $error("R4: written line not dirty");

  p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_en && mark_en))
    else $error("R9: load and byte write in one cycle");
endmodule

// File: rtl/dmwb_data_store.sv
`timescale 1ns/1ps
module dmwb_data_store #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned OFF_W = 4,
  localparam int unsigned LINES  = 1 << IDX_W,
  localparam int unsigned LINE_W = 8 << OFF_W
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  look_idx,
  output logic [LINE_W-1:0] look_line,
  input  logic              load_en,
  input  logic [IDX_W-1:0]  load_idx,
  input  logic [LINE_W-1:0] load_line,
  input  logic              byte_en,
  input  logic [IDX_W-1:0]  byte_idx,
  input  logic [OFF_W-1:0]  byte_off,
  input  logic [7:0]        byte_val
);
  logic [LINE_W-1:0] line_q [LINES];

  always_ff @(posedge clk) begin
    if (load_en) begin
      line_q[load_idx] <= load_line;
    end else if (byte_en) begin
      line_q[byte_idx][{byte_off, 3'b000} +: 8] <= byte_val;
    end
  end

  assign look_line = line_q[look_idx];
endmodule

// File: rtl/dmwb_miss_seq.sv
`timescale 1ns/1ps
module dmwb_miss_seq
  import dmwb_cache_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic hit,
  input  logic line_valid,
  input  logic line_dirty,
  input  logic mem_ready,
  output logic mem_valid,
  output logic mem_we,
  output logic load_done,
  output logic idle
);
  miss_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (req && !hit) st_d = (line_valid && line_dirty) ? ST_SAVE : ST_LOAD;
      ST_SAVE: if (mem_ready) st_d = ST_LOAD;
      ST_LOAD: if (mem_ready) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    idle      = (st_q == ST_IDLE);
    mem_valid = (st_q != ST_IDLE);
    mem_we    = (st_q == ST_SAVE);
    load_done = (st_q == ST_LOAD) && mem_ready;
  end

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && (mem_we == $past(mem_we)))
    else $error("R10: memory request dropped or changed while stalled");

  p_save_then_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we && mem_ready |=> mem_valid && !mem_we)
    else $error("R7: save not followed by load");

  p_load_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> !mem_valid)
    else $error("R8: request still open after load");
endmodule

// File: rtl/dmwb_cache.sv
`timescale 1ns/1ps
module dmwb_cache #(
  parameter int unsigned ADDR_W = dmwb_cache_pkg::ADDR_BITS,
  parameter int unsigned IDX_W  = dmwb_cache_pkg::IDX_BITS,
  parameter int unsigned OFF_W  = dmwb_cache_pkg::OFF_BITS,
  localparam int unsigned TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int unsigned BLK_W  = ADDR_W - OFF_W,
  localparam int unsigned LINE_W = 8 << OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [BLK_W-1:0]  mem_addr,
  output logic [LINE_W-1:0] mem_wdata,
  input  logic [LINE_W-1:0] mem_rdata
);
  logic [TAG_W-1:0]  a_tag;
  logic [IDX_W-1:0]  a_idx;
  logic [OFF_W-1:0]  a_off;
  logic [TAG_W-1:0]  s_tag;
  logic              s_valid, s_dirty;
  logic [LINE_W-1:0] s_line;
  logic              hit, idle, load_done, byte_wr;

  dmwb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_split (
    .addr(cpu_addr), .tag(a_tag), .idx(a_idx), .off(a_off)
  );

  dmwb_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .look_idx(a_idx), .look_tag(s_tag), .look_valid(s_valid), .look_dirty(s_dirty),
    .load_en(load_done), .load_idx(a_idx), .load_tag(a_tag),
    .mark_en(byte_wr), .mark_idx(a_idx)
  );

  dmwb_data_store #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_data (
    .clk(clk),
    .look_idx(a_idx), .look_line(s_line),
    .load_en(load_done), .load_idx(a_idx), .load_line(mem_rdata),
    .byte_en(byte_wr), .byte_idx(a_idx), .byte_off(a_off), .byte_val(cpu_wdata)
  );

  dmwb_miss_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .req(cpu_valid), .hit(hit), .line_valid(s_valid), .line_dirty(s_dirty),
    .mem_ready(mem_ready), .mem_valid(mem_valid), .mem_we(mem_we),
    .load_done(load_done), .idle(idle)
  );

  always_comb begin
    hit       = s_valid && (s_tag == a_tag);
    cpu_ready = cpu_valid && hit && idle;
    byte_wr   = cpu_ready && cpu_we;
    cpu_rdata = s_line[{a_off, 3'b000} +: 8];
    mem_addr  = mem_we ? {s_tag, a_idx} : {a_tag, a_idx};
    mem_wdata = s_line;
  end

  p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !cpu_ready)
    else $error("R11: processor released during memory transfer");

  p_save_dirty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we |-> s_valid && s_dirty && (s_tag != a_tag))
    else $error("R7: save of a line that is not a dirty victim");

  p_payload_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> $stable(mem_addr) && $stable(mem_wdata))
    else $error("R10: memory payload changed while stalled");

  p_hit_after_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_done && cpu_valid |=> cpu_valid |-> cpu_ready)
    else $error("R8: no hit after block load");

  p_hit_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !mem_valid)
    else $error("R12: memory request during a hit");
endmodule

// File: tb/sim_dmwb_cache.sv
`timescale 1ns/1ps
module sim_dmwb_cache;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cpu_valid = 1'b0;
  logic         cpu_ready;
  logic         cpu_we = 1'b0;
  logic [23:0]  cpu_addr = '0;
  logic [7:0]   cpu_wdata = '0;
  logic [7:0]   cpu_rdata;
  logic         mem_valid;
  logic         mem_ready = 1'b0;
  logic         mem_we;
  logic [19:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic [127:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  dmwb_cache u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench memory and line model
  logic [127:0] mmem [logic [19:0]];
  logic         m_valid [256];
  logic         m_dirty [256];
  logic [11:0]  m_tag   [256];
  logic [127:0] m_line  [256];

  // Transfer log filled by the memory responder
  logic [19:0]  lg_addr  [4];
  logic         lg_we    [4];
  logic [127:0] lg_wdata [4];
  int           lg_n = 0;

  function automatic logic [127:0] blk_init(input logic [19:0] b);
    logic [127:0] v;
    for (int i = 0; i < 16; i++)
      v[8*i +: 8] = b[7:0] ^ b[15:8] ^ {4'h0, b[19:16]} ^ (8'(i) * 8'h1D) ^ 8'h5A;
    return v;
  endfunction

  function automatic logic [127:0] mem_get(input logic [19:0] b);
    if (mmem.exists(b)) return mmem[b];
    return blk_init(b);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Memory responder: random latency, checks request stability (R10)
  initial begin : responder
    bit          seen = 0;
    logic [19:0] a0 = '0;
    logic        w0 = 1'b0;
    logic [127:0] d0 = '0;
    int          dly = 0;
    forever begin
      @(negedge clk);
      if (mem_ready) begin
        mem_ready = 1'b0;
      end else if (mem_valid) begin
        if (!seen) begin
          seen = 1; a0 = mem_addr; w0 = mem_we; d0 = mem_wdata;
          dly = $urandom_range(0, 3);
        end
        if (dly == 0) begin
          chk(a0 == mem_addr && w0 == mem_we && (!w0 || d0 == mem_wdata),
              "R10 request stable", {mem_we, mem_addr}, {w0, a0});
          if (lg_n < 4) begin
            lg_addr[lg_n] = mem_addr; lg_we[lg_n] = mem_we; lg_wdata[lg_n] = mem_wdata;
          end
          lg_n++;
          if (mem_we) mmem[mem_addr] = mem_wdata;
          mem_rdata = mem_get(mem_addr);
          mem_ready = 1'b1;
          seen = 0;
        end else begin
          dly--;
        end
      end
    end
  end

  // One processor access, called right after a falling edge
  task automatic access(input logic we, input logic [23:0] a, input logic [7:0] d, input string tag);
    logic [11:0] tg  = a[23:12];
    logic [7:0]  ix  = a[11:4];
    logic [3:0]  of  = a[3:0];
    bit          eh  = m_valid[ix] && m_tag[ix] == tg;
    bit          ewb = !eh && m_valid[ix] && m_dirty[ix];
    logic [19:0] vb  = {m_tag[ix], ix};
    logic [127:0] vd = m_line[ix];
    logic [7:0]  rd;
    int          cyc = 0;
    lg_n = 0;
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    #1;
    while (!cpu_ready && cyc < 100) begin
      @(negedge clk); #1; cyc++;
    end
    rd = cpu_rdata;
    if (eh) begin
      chk(cyc == 0, {"R3 hit same cycle ", tag}, cyc, 0);
      chk(lg_n == 0, {"R12 no memory on hit ", tag}, lg_n, 0);
    end else begin
      chk(cyc > 1, {"R11 stall on miss ", tag}, cyc, 2);
      chk(lg_n == (ewb ? 2 : 1), {ewb ? "R7 transfer count " : "R6 R5 transfer count ", tag},
          lg_n, ewb ? 2 : 1);
      if (ewb && lg_n == 2) begin
        chk(lg_we[0] && lg_addr[0] == vb, {"R7 save address ", tag}, {lg_we[0], lg_addr[0]}, {1'b1, vb});
        chk(lg_wdata[0] == vd, {"R7 save data ", tag}, lg_wdata[0], vd);
      end
      if (lg_n >= 1 && lg_n <= 2) begin
        chk(!lg_we[lg_n-1] && lg_addr[lg_n-1] == {tg, ix}, {"R1 load address ", tag},
            {lg_we[lg_n-1], lg_addr[lg_n-1]}, {1'b0, tg, ix});
      end
      m_line[ix] = mem_get({tg, ix});
      m_valid[ix] = 1'b1; m_dirty[ix] = 1'b0; m_tag[ix] = tg;
    end
    if (!we) begin
      chk(rd == m_line[ix][8*of +: 8], {"R3 read data ", tag}, rd, m_line[ix][8*of +: 8]);
    end else begin
      m_line[ix][8*of +: 8] = d;
      m_dirty[ix] = 1'b1;
    end
    @(negedge clk);
    cpu_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int seed;
    logic [11:0] tg_set [4];
    logic [7:0]  ix_set [4];
    seed = $urandom(32'd20240611);
    tg_set[0] = 12'hAB7; tg_set[1] = 12'h895; tg_set[2] = 12'hCD4; tg_set[3] = 12'h543;
    ix_set[0] = 8'h12;   ix_set[1] = 8'h00;   ix_set[2] = 8'hFF;   ix_set[3] = 8'h34;
    for (int i = 0; i < 256; i++) begin
      m_valid[i] = 1'b0; m_dirty[i] = 1'b0; m_tag[i] = '0; m_line[i] = '0;
    end
    repeat (3) @(negedge clk);
    chk(!mem_valid && !cpu_ready, "R2 reset outputs idle", {mem_valid, cpu_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_valid, "R2 no request after reset", mem_valid, 0);

    // Directed corner cases
    access(1'b0, 24'hAB7129, 8'h00, "R2 R5 first read miss");
    access(1'b0, 24'hAB7123, 8'h00, "R8 read after load");
    access(1'b1, 24'hAB712C, 8'hE1, "R4 write hit");
    access(1'b0, 24'hAB712C, 8'h00, "R4 read back byte");
    access(1'b0, 24'hAB712B, 8'h00, "R4 neighbour byte kept");
    access(1'b0, 24'h895123, 8'h00, "R7 dirty victim");
    access(1'b0, 24'hCD4120, 8'h00, "R6 clean victim");
    access(1'b1, 24'h543126, 8'h77, "R9 write miss");
    access(1'b0, 24'h543126, 8'h00, "R9 merged byte");
    access(1'b0, 24'hAB712C, 8'h00, "R9 evict merged line");
    access(1'b0, 24'h000FF0, 8'h00, "R1 top index");
    access(1'b0, 24'hFFF00F, 8'h00, "R1 bottom index");

    // Constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic [23:0] a;
      a = {tg_set[$urandom_range(0, 3)], ix_set[$urandom_range(0, 3)], 4'($urandom_range(0, 15))};
      access(1'($urandom_range(0, 1)), a, 8'($urandom_range(0, 255)), "random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule